// File: doc/BRIEF.md
# Software Watchdog with Latched Status Flag

This block supervises running software through a strobe line. Software shows it is alive by pulling the strobe from high to low. Each such edge starts a new timing period. If a whole period of time-base ticks passes with no edge, the block issues a one-cycle timeout request to the reset generator. It also sets an active-low status flag, which stays set until something releases it.

Ticks come from two sources, an internal one and an external one, and a select input chooses which source is counted. Counting is held off in three cases: while the reset generator reports that reset is active, while the supply is flagged low, and while the strobe is reported as disconnected. A disconnected strobe also releases the status flag. A low supply forces the flag active.

Top module: `wdt_latched_top`

## Requirements
- R1: While `reset_active_i` is high, the count is held at zero and no timeout request is issued, however many ticks arrive.
- R2: Once counting is enabled, the PERIOD_TICKS-th selected tick after a fresh start raises `timeout_req_o` for exactly one cycle. That cycle is the one that follows the clock edge taking the tick. Counting then starts over from zero.
- R3: The clock edge that takes the expiring tick also drives `status_n_o` low.
- R4: `status_n_o` holds its value when no release, force or expiry condition is present. Later ticks do not change it.
- R5: A falling strobe edge clears the count and sets `status_n_o` high. A falling edge is the strobe going from high to low and staying low for two consecutive synchronized samples. With two synchronizer stages, the effect is seen after the fourth rising clock edge that follows the input falling.
- R6: A strobe low pulse lasting a single clock cycle is not taken as an edge. The status flag and the count are left unchanged.
- R7: While `strobe_open_i` is high, `status_n_o` goes high on the next edge and no counting takes place. The count restarts from zero once the input drops.
- R8: While `supply_low_i` is high, `status_n_o` goes low on the next edge and no counting takes place. After the supply recovers, the flag stays low until it is released.
- R9: When `base_sel_i` is 1, only `tick_ext_i` is counted. When it is 0, only `tick_int_i` is counted. The unselected tick has no effect.
- R10: After the synchronous reset, `status_n_o` is high and `timeout_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_int_i | input | 1 | Internal time-base tick, one cycle wide |
| tick_ext_i | input | 1 | External time-base tick, one cycle wide |
| base_sel_i | input | 1 | Time-base select: 1 = external, 0 = internal |
| strobe_i | input | 1 | Asynchronous software strobe; a falling edge services the watchdog |
| strobe_open_i | input | 1 | Strobe reported disconnected; disables the watchdog |
| supply_low_i | input | 1 | Supply below trip point |
| reset_active_i | input | 1 | Reset generator is currently asserting reset |
| timeout_req_o | output | 1 | One-cycle timeout request to the reset generator |
| status_n_o | output | 1 | Latched watchdog status, active low |

## Verification
The first pattern sends ticks while reset is held, then while it is released. This separates gated counting from free counting, and the count that lands exactly on the period shows an off-by-one error.

Other patterns restart the period partway through: once with a real falling edge and once with a single-cycle low glitch. If the timeout arrives at a different point in each case, the edge filter is shown to be working. The open-strobe and low-supply windows show the release and force conditions and whether the latch survives supply recovery. Sending ticks on the unselected source shows the time-base select.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WDT_DEF_PERIOD = 8;
    localparam int unsigned WDT_DEF_SYNC   = 2;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_FORCE   = 2'd1,
        ACT_RELEASE = 2'd2,
        ACT_SET     = 2'd3
    } status_act_e;

    typedef struct packed {
        logic active;
        logic restart;
        logic tick;
    } cnt_ctrl_t;

    // Priority: low supply, then disconnected strobe, then edge, then expiry.
    function automatic status_act_e pick_status_act(
        input logic supply_low,
        input logic open_strobe,
        input logic fall,
        input logic expire
    );
        if (supply_low)       return ACT_FORCE;
        else if (open_strobe) return ACT_RELEASE;
        else if (fall)        return ACT_RELEASE;
        else if (expire)      return ACT_SET;
        else                  return ACT_HOLD;
    endfunction

endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
    parameter int unsigned SYNC_STAGES = wdt_pkg::WDT_DEF_SYNC
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic strobe_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   hist1_q;
    logic                   hist2_q;
    logic                   synced;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= 1'b1;
                    else       chain_q[0] <= strobe_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[g] <= 1'b1;
                    else       chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign synced = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hist1_q <= 1'b1;
            hist2_q <= 1'b1;
        end else begin
            hist1_q <= synced;
            hist2_q <= hist1_q;
        end
    end

    // high, then low on two consecutive synchronized samples
    assign fall_o = hist2_q & ~hist1_q & ~synced;

    AST_FALL_NOT_REPEATED: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |=> !fall_o); // R6

endmodule

// File: rtl/wdt_period_counter.sv
module wdt_period_counter #(
    parameter int unsigned PERIOD_TICKS = wdt_pkg::WDT_DEF_PERIOD
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  wdt_pkg::cnt_ctrl_t  ctrl_i,
    output logic                expire_o,
    output logic                timeout_o
);
    localparam int unsigned CW = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          tmo_q;

    initial begin
        if (PERIOD_TICKS < 2) $error("PERIOD_TICKS must be at least 2");
    end

    assign expire_o = ctrl_i.active & ~ctrl_i.restart & ctrl_i.tick & (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !ctrl_i.active || ctrl_i.restart) begin
            cnt_q <= '0;
        end else if (ctrl_i.tick) begin
            cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) tmo_q <= 1'b0;
        else       tmo_q <= expire_o;
    end

    assign timeout_o = tmo_q;

    AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_i.active |=> cnt_q == '0); // R1
    AST_IDLE_NO_TIMEOUT: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_i.active |=> !timeout_o); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |=> !timeout_o); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST); // R2
    AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_i.restart |=> cnt_q == '0); // R5

endmodule

// File: rtl/wdt_status_latch.sv
module wdt_status_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic supply_low_i,
    input  logic strobe_open_i,
    input  logic fall_i,
    input  logic expire_i,
    output logic status_n_o
);
    import wdt_pkg::*;

    status_act_e act;
    logic        stat_n_q;

    assign act = pick_status_act(supply_low_i, strobe_open_i, fall_i, expire_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_n_q <= 1'b1;
        end else begin
            unique case (act)
                ACT_FORCE:   stat_n_q <= 1'b0;
                ACT_SET:     stat_n_q <= 1'b0;
                ACT_RELEASE: stat_n_q <= 1'b1;
                default:     stat_n_q <= stat_n_q;
            endcase
        end
    end

    assign status_n_o = stat_n_q;

    AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        supply_low_i |=> !status_n_o); // R8
    AST_OPEN_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
        (!supply_low_i && strobe_open_i) |=> status_n_o); // R7
    AST_EDGE_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
        (!supply_low_i && fall_i) |=> status_n_o); // R5
    AST_EXPIRY_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
        (expire_i && !strobe_open_i) |=> !status_n_o); // R3
    AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!supply_low_i && !strobe_open_i && !fall_i && !expire_i) |=> $stable(status_n_o)); // R4

endmodule

// File: rtl/wdt_latched_top.sv
module wdt_latched_top #(
    parameter int unsigned PERIOD_TICKS = wdt_pkg::WDT_DEF_PERIOD,
    parameter int unsigned SYNC_STAGES  = wdt_pkg::WDT_DEF_SYNC
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_int_i,
    input  logic tick_ext_i,
    input  logic base_sel_i,
    input  logic strobe_i,
    input  logic strobe_open_i,
    input  logic supply_low_i,
    input  logic reset_active_i,
    output logic timeout_req_o,
    output logic status_n_o
);
    import wdt_pkg::*;

    logic      fall;
    logic      expire;
    logic      tick_sel;
    cnt_ctrl_t ctrl;

    assign tick_sel = base_sel_i ? tick_ext_i : tick_int_i;

    assign ctrl.active  = ~reset_active_i & ~supply_low_i & ~strobe_open_i;
    assign ctrl.restart = fall;
    assign ctrl.tick    = tick_sel;

    wdt_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (strobe_i),
        .fall_o   (fall)
    );

    wdt_period_counter #(.PERIOD_TICKS(PERIOD_TICKS)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ctrl_i    (ctrl),
        .expire_o  (expire),
        .timeout_o (timeout_req_o)
    );

    wdt_status_latch u_stat (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .supply_low_i  (supply_low_i),
        .strobe_open_i (strobe_open_i),
        .fall_i        (fall),
        .expire_i      (expire),
        .status_n_o    (status_n_o)
    );

    AST_RESET_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        reset_active_i |=> !timeout_req_o); // R1
    AST_TIMEOUT_WITH_STATUS: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_req_o |-> !status_n_o || $past(strobe_open_i)); // R3

endmodule

// File: tb/wdt_latched_top_bench.sv
module wdt_latched_top_bench;
    localparam int unsigned P = 5;

    logic clk = 1'b0;
    logic rst, tick_int, tick_ext, base_sel, strobe, strobe_open, supply_low, reset_active;
    logic timeout_req, status_n;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_latched_top #(.PERIOD_TICKS(P), .SYNC_STAGES(2)) u_wdt_latched_top (
        .clk_i(clk), .rst_i(rst), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
        .base_sel_i(base_sel), .strobe_i(strobe), .strobe_open_i(strobe_open),
        .supply_low_i(supply_low), .reset_active_i(reset_active),
        .timeout_req_o(timeout_req), .status_n_o(status_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // one tick on the chosen source; returns at the negedge after the taking edge
    task automatic send_tick(input bit ext, input logic exp_tmo, input string req);
        if (ext) tick_ext = 1'b1; else tick_int = 1'b1;
        @(negedge clk);
        tick_ext = 1'b0;
        tick_int = 1'b0;
        check(req, timeout_req, exp_tmo);
    endtask

    task automatic strobe_fall(input string req);
        strobe = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        check(req, status_n, 1'b1);
    endtask

    task automatic strobe_restore();
        strobe = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R10 status", status_n, 1'b1);
        check("R10 timeout", timeout_req, 1'b0);
    endtask

    task automatic t_reset_hold();
        for (int i = 0; i < 2*P; i++) send_tick(1'b0, 1'b0, "R1 no timeout in reset");
        check("R1 status", status_n, 1'b1);
    endtask

    task automatic t_expiry();
        reset_active = 1'b0;
        @(negedge clk);
        for (int i = 0; i < P-1; i++) send_tick(1'b0, 1'b0, "R2 early");
        send_tick(1'b0, 1'b1, "R2 expiry");
        check("R3 status set", status_n, 1'b0);
        @(negedge clk);
        check("R2 single cycle", timeout_req, 1'b0);
        check("R4 latched", status_n, 1'b0);
        send_tick(1'b0, 1'b0, "R4 tick");
        send_tick(1'b0, 1'b0, "R4 tick");
        check("R4 still latched", status_n, 1'b0);
    endtask

    task automatic t_strobe_edge();
        // count is 2 here; without a restart expiry would come after 3 ticks
        strobe = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 not yet", status_n, 1'b0);
        @(negedge clk);
        check("R5 released", status_n, 1'b1);
        for (int i = 0; i < P-1; i++) send_tick(1'b0, 1'b0, "R5 restarted");
        strobe_restore();
        send_tick(1'b0, 1'b1, "R5 full period");
    endtask

    task automatic t_glitch();
        strobe = 1'b0;
        @(negedge clk);
        strobe = 1'b1;
        repeat (5) @(negedge clk);
        check("R6 glitch ignored status", status_n, 1'b0);
        for (int i = 0; i < P-1; i++) send_tick(1'b0, 1'b0, "R6 early");
        send_tick(1'b0, 1'b1, "R6 count kept");
    endtask

    task automatic t_open();
        strobe_open = 1'b1;
        @(negedge clk);
        check("R7 released", status_n, 1'b1);
        for (int i = 0; i < 2*P; i++) send_tick(1'b0, 1'b0, "R7 disabled");
        strobe_open = 1'b0;
        @(negedge clk);
        for (int i = 0; i < P-1; i++) send_tick(1'b0, 1'b0, "R7 fresh");
        send_tick(1'b0, 1'b1, "R7 expiry after open");
    endtask

    task automatic t_supply();
        strobe_fall("R5 release before supply");
        strobe_restore();
        supply_low = 1'b1;
        @(negedge clk);
        check("R8 forced", status_n, 1'b0);
        for (int i = 0; i < 2*P; i++) send_tick(1'b0, 1'b0, "R8 disabled");
        supply_low = 1'b0;
        @(negedge clk);
        check("R8 kept after recovery", status_n, 1'b0);
        strobe_fall("R8 released by edge");
        strobe_restore();
    endtask

    task automatic t_base_sel();
        base_sel = 1'b1;
        @(negedge clk);
        for (int i = 0; i < P; i++) send_tick(1'b0, 1'b0, "R9 internal ignored");
        check("R9 status", status_n, 1'b1);
        for (int i = 0; i < P-1; i++) send_tick(1'b1, 1'b0, "R9 ext early");
        send_tick(1'b1, 1'b1, "R9 ext expiry");
        base_sel = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; tick_int = 1'b0; tick_ext = 1'b0; base_sel = 1'b0;
        strobe = 1'b1; strobe_open = 1'b0; supply_low = 1'b0; reset_active = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_reset_hold();
        t_expiry();
        t_strobe_edge();
        t_glitch();
        t_open();
        t_supply();
        t_base_sel();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule